// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR-class SDRAM from reset to a usable state. It holds the clock-enable pin low and keeps the command bus idle while supply and clock settle. Once a power-stable flag has stayed high for a settling time, it raises clock-enable. It then issues a fixed sequence of commands:

- precharge-all
- extended mode register write, which enables the DLL
- mode register write with DLL reset
- a second precharge-all
- a series of auto-refresh commands
- a final mode register write that programs the operating mode

The block spaces the commands by parameterized minimum gaps. It raises its done flag only when the final write has settled and the DLL has had its lock time.

After the done flag is high, a normal memory controller takes the bus. While the block is done, its own outputs stay idle (NOP, clock-enable high).

When the clock frequency changes, a single-cycle request makes the block do three things:

- drop done
- issue a new DLL-reset mode register write
- wait out the lock time again

It does not repeat the full initialization.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, `cke` is 0 and `cmd` is NOP. `cke` rises, with NOP on the bus, after the P-th consecutive clock edge at which `pwr_stable` is sampled 1, where P = CLK_MHZ*PWRUP_US. A 0 sample restarts the count.
- R2: Once `cke` is 1 it stays 1 until reset.
- R3: The `cmd` bits are {cs_n, ras_n, cas_n, we_n}, with these codes:
  - NOP = 0111
  - precharge = 0010, with only address bit 10 set (all banks)
  - auto-refresh = 0001, with address 0
  - mode register write = 0000

  Every non-NOP command lasts exactly one cycle.
- R4: Precharge-all comes one clock after `cke` rises. An extended mode write follows T_RP clocks later, with `ba` = 1 and `addr` = EMODE_VAL.
- R5: A mode write with `ba` = 0 and `addr` = MODE_VAL with bit 8 set (DLL reset) comes T_EMRS clocks after the extended mode write.
- R6: A second precharge-all comes T_MRS clocks after the DLL-reset write.
- R7: N_REF auto-refresh commands follow. The first comes T_RP clocks after the second precharge, and each later one T_RFC clocks after the previous one.
- R8: A mode write with `ba` = 0 and `addr` = MODE_VAL with bit 8 clear comes T_RFC clocks after the last refresh.
- R9: `init_done` rises at the later of two times: T_MRS clocks after the final mode write, and T_DLL clocks after the DLL-reset write. While `init_done` is 1, `cmd` is NOP and `cke` is 1.
- R10: A `freq_chg_req` sampled while `init_done` is 1 drops `init_done` in the cycle where a DLL-reset mode write (`addr` = MODE_VAL with bit 8 set, `ba` = 0) appears. `init_done` returns T_DLL clocks later, and no other command is issued in between.
- R11: A `freq_chg_req` sampled before `init_done` first rises has no effect on the command sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_stable | input | 1 | Supply and clock are stable |
| freq_chg_req | input | 1 | Request a DLL relock after a clock frequency change |
| cke | output | 1 | SDRAM clock enable |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode register value |
| init_done | output | 1 | Initialization complete; bus handed over |

## Verification
The bench breaks the power-stable flag with random glitches shorter than the settling time. A design that keeps counting across a glitch would raise clock-enable early, and the bench catches that by comparing against the length of the final unbroken run.

The bench records the whole command trace and compares each code, bank, address and gap with values it computes itself. A swapped step, a wrong gap, or the DLL-reset bit left set in the final write all show up as a mismatch.

A frequency-change pulse injected during initialization must leave the trace unchanged. A design that obeys it would add an extra mode write.

Pulses injected after done must produce exactly one DLL-reset write and an idle bus for precisely the lock time. A design that reuses a stale lock count, or lets done come back early, misses that cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } dram_cmd_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_PREA,
      OP_REF,
      OP_EMRS,
      OP_MRS_DLL,
      OP_MRS_OP
   } issue_e;

   typedef enum logic [3:0] {
      S_PWR,
      S_PRE1,
      S_EMRS,
      S_DLLRST,
      S_PRE2,
      S_REF,
      S_MODE,
      S_SETTLE,
      S_DONE,
      S_RELOCK
   } seq_state_e;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int             W       = 8,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   // Loadable down counter that parks at zero.
   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= RST_VAL;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
#(
   parameter int                ADDR_W      = 13,
   parameter int                BA_W        = 2,
   parameter int                DLL_RST_BIT = 8,
   parameter int                PREA_BIT    = 10,
   parameter logic [ADDR_W-1:0] MODE_VAL    = 'h032,
   parameter logic [ADDR_W-1:0] EMODE_VAL   = 'h000
) (
   input  issue_e            op,
   output logic [3:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
   localparam logic [ADDR_W-1:0] PREA_VAL = ADDR_W'(1) << PREA_BIT;

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      case (op)
         OP_PREA: begin
            cmd  = CMD_PRE;
            addr = PREA_VAL;
         end
         OP_REF: cmd = CMD_REF;
         OP_EMRS: begin
            cmd  = CMD_MRS;
            ba   = BA_W'(1);
            addr = EMODE_VAL;
         end
         OP_MRS_DLL: begin
            cmd  = CMD_MRS;
            addr = MODE_VAL | DLL_MASK;
         end
         OP_MRS_OP: begin
            cmd  = CMD_MRS;
            addr = MODE_VAL & ~DLL_MASK;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int                CLK_MHZ     = 125,
   parameter int                PWRUP_US    = 200,
   parameter int                T_RP        = 4,
   parameter int                T_EMRS      = 20,
   parameter int                T_MRS       = 2,
   parameter int                T_RFC       = 12,
   parameter int                N_REF       = 2,
   parameter int                T_DLL       = 200,
   parameter int                ADDR_W      = 13,
   parameter int                BA_W        = 2,
   parameter int                DLL_RST_BIT = 8,
   parameter int                PREA_BIT    = 10,
   parameter logic [ADDR_W-1:0] MODE_VAL    = 'h032,
   parameter logic [ADDR_W-1:0] EMODE_VAL   = 'h000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_stable,
   input  logic              freq_chg_req,
   output logic              cke,
   output logic [3:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
   localparam int STEP_W  = $clog2(PWR_CYC + T_EMRS + T_RFC + T_RP + T_MRS + 1);
   localparam int LOCK_W  = $clog2(T_DLL + 1);
   localparam int REF_W   = $clog2(N_REF + 1);

   // Elaboration-time parameter checks
   if (PWR_CYC < 1)            begin : g_bad_pwr  $error("power-up wait must be nonzero");      end
   if (T_RP < 2)               begin : g_bad_trp  $error("T_RP must be at least 2");            end
   if (T_EMRS < 20)            begin : g_bad_temr $error("T_EMRS must be at least 20");         end
   if (T_MRS < 2)              begin : g_bad_tmrs $error("T_MRS must be at least 2");           end
   if (T_RFC < 2)              begin : g_bad_trfc $error("T_RFC must be at least 2");           end
   if (N_REF < 2)              begin : g_bad_nref $error("N_REF must be at least 2");           end
   if (T_DLL < 200)            begin : g_bad_tdll $error("T_DLL must be at least 200");         end
   if (PREA_BIT >= ADDR_W)     begin : g_bad_pab  $error("PREA_BIT outside address");           end
   if (DLL_RST_BIT >= ADDR_W)  begin : g_bad_dlb  $error("DLL_RST_BIT outside address");        end
   else if (MODE_VAL[DLL_RST_BIT]) begin : g_bad_mv $error("MODE_VAL must keep DLL reset clear"); end

   seq_state_e          state_q, state_d;
   issue_e              op;
   logic                st_load, st_zero, lk_load, lk_zero;
   logic [STEP_W-1:0]   st_val;
   logic [REF_W-1:0]    ref_q;
   logic                ref_inc, ref_clr;
   logic                cke_set, done_set, done_clr;
   logic                cke_q, done_q;
   logic [3:0]          enc_cmd, cmd_q;
   logic [BA_W-1:0]     enc_ba, ba_q;
   logic [ADDR_W-1:0]   enc_addr, addr_q;

   ddr_init_timer #(.W(STEP_W), .RST_VAL(STEP_W'(PWR_CYC - 1))) u_step_tmr (
      .clk(clk), .rst_n(rst_n), .load(st_load), .load_val(st_val), .zero(st_zero)
   );

   ddr_init_timer #(.W(LOCK_W), .RST_VAL('0)) u_lock_tmr (
      .clk(clk), .rst_n(rst_n), .load(lk_load),
      .load_val(LOCK_W'(T_DLL - 1)), .zero(lk_zero)
   );

   ddr_init_cmd_enc #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .DLL_RST_BIT(DLL_RST_BIT), .PREA_BIT(PREA_BIT),
      .MODE_VAL(MODE_VAL), .EMODE_VAL(EMODE_VAL)
   ) u_enc (
      .op(op), .cmd(enc_cmd), .ba(enc_ba), .addr(enc_addr)
   );

   always_comb begin
      state_d  = state_q;
      op       = OP_NONE;
      st_load  = 1'b0;
      st_val   = '0;
      lk_load  = 1'b0;
      ref_inc  = 1'b0;
      ref_clr  = 1'b0;
      cke_set  = 1'b0;
      done_set = 1'b0;
      done_clr = 1'b0;
      case (state_q)
         S_PWR: begin
            if (!pwr_stable) begin
               st_load = 1'b1;
               st_val  = STEP_W'(PWR_CYC - 1);
            end else if (st_zero) begin
               cke_set = 1'b1;
               st_load = 1'b1;
               state_d = S_PRE1;
            end
         end
         S_PRE1: if (st_zero) begin
            op = OP_PREA; st_load = 1'b1; st_val = STEP_W'(T_RP - 1); state_d = S_EMRS;
         end
         S_EMRS: if (st_zero) begin
            op = OP_EMRS; st_load = 1'b1; st_val = STEP_W'(T_EMRS - 1); state_d = S_DLLRST;
         end
         S_DLLRST: if (st_zero) begin
            op = OP_MRS_DLL; lk_load = 1'b1;
            st_load = 1'b1; st_val = STEP_W'(T_MRS - 1); state_d = S_PRE2;
         end
         S_PRE2: if (st_zero) begin
            op = OP_PREA; st_load = 1'b1; st_val = STEP_W'(T_RP - 1);
            ref_clr = 1'b1; state_d = S_REF;
         end
         S_REF: if (st_zero) begin
            op = OP_REF; st_load = 1'b1; st_val = STEP_W'(T_RFC - 1); ref_inc = 1'b1;
            if (ref_q == REF_W'(N_REF - 1)) state_d = S_MODE;
         end
         S_MODE: if (st_zero) begin
            op = OP_MRS_OP; st_load = 1'b1; st_val = STEP_W'(T_MRS - 1); state_d = S_SETTLE;
         end
         S_SETTLE: if (st_zero && lk_zero) begin
            done_set = 1'b1; state_d = S_DONE;
         end
         S_DONE: if (freq_chg_req) begin
            op = OP_MRS_DLL; lk_load = 1'b1; done_clr = 1'b1; state_d = S_RELOCK;
         end
         S_RELOCK: if (lk_zero) begin
            done_set = 1'b1; state_d = S_DONE;
         end
         default: state_d = S_PWR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_PWR;
         ref_q   <= '0;
         cke_q   <= 1'b0;
         done_q  <= 1'b0;
         cmd_q   <= CMD_NOP;
         ba_q    <= '0;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (ref_clr)      ref_q <= '0;
         else if (ref_inc) ref_q <= ref_q + 1'b1;
         if (cke_set)       cke_q  <= 1'b1;
         if (done_set)      done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;
         cmd_q  <= enc_cmd;
         ba_q   <= enc_ba;
         addr_q <= enc_addr;
      end
   end

   assign cke       = cke_q;
   assign cmd       = cmd_q;
   assign ba        = ba_q;
   assign addr      = addr_q;
   assign init_done = done_q;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int T_DLL       = 200,
   parameter int ADDR_W      = 13,
   parameter int DLL_RST_BIT = 8,
   parameter int PREA_BIT    = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic [3:0]        cmd,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done
);

   localparam int CW = $clog2(T_DLL + 1);
   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] MRS = 4'b0000;
   localparam logic [3:0] PRE = 4'b0010;

   logic [CW-1:0] since_dll_q;
   logic          dll_mrs;

   assign dll_mrs = (cmd == MRS) && addr[DLL_RST_BIT];

   // Cycles since the last DLL-reset write, saturating at T_DLL.
   always_ff @(posedge clk) begin
      if (!rst_n)                           since_dll_q <= '0;
      else if (dll_mrs)                     since_dll_q <= CW'(1);
      else if (since_dll_q != CW'(T_DLL) && since_dll_q != '0)
                                            since_dll_q <= since_dll_q + 1'b1;
   end

   p_nop_while_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> cmd == NOP);

   p_cke_no_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   p_cmd_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd != NOP |=> cmd == NOP);

   p_prea_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == PRE |-> addr[PREA_BIT]);

   p_done_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd == NOP) && cke);

   p_dll_lock_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> since_dll_q == CW'(T_DLL));

   p_done_fall_on_dll_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init_done) |-> dll_mrs);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
   .T_DLL(T_DLL), .ADDR_W(ADDR_W), .DLL_RST_BIT(DLL_RST_BIT), .PREA_BIT(PREA_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .addr(addr), .init_done(init_done)
);

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;

   localparam int CLK_MHZ  = 125;
   localparam int PWRUP_US = 2;
   localparam int P        = CLK_MHZ * PWRUP_US;
   localparam int T_RP     = 4;
   localparam int T_EMRS   = 20;
   localparam int T_MRS    = 2;
   localparam int T_RFC    = 12;
   localparam int N_REF    = 3;
   localparam int T_DLL    = 200;
   localparam int ADDR_W   = 13;
   localparam int BA_W     = 2;
   localparam logic [ADDR_W-1:0] MODE_VAL  = 13'h062;
   localparam logic [ADDR_W-1:0] EMODE_VAL = 13'h004;
   localparam int NE = 5 + N_REF;

   logic clk = 1'b0;
   logic rst_n, pwr_stable, freq_chg_req;
   logic cke, init_done;
   logic [3:0] cmd;
   logic [BA_W-1:0] ba;
   logic [ADDR_W-1:0] addr;

   always #4 clk = ~clk;

   ddr_init_seq #(
      .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_EMRS(T_EMRS),
      .T_MRS(T_MRS), .T_RFC(T_RFC), .N_REF(N_REF), .T_DLL(T_DLL),
      .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_VAL(MODE_VAL), .EMODE_VAL(EMODE_VAL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable), .freq_chg_req(freq_chg_req),
      .cke(cke), .cmd(cmd), .ba(ba), .addr(addr), .init_done(init_done)
   );

   int n_chk = 0, n_err = 0;
   int cyc = 0, hi_run = 0;
   bit rec = 1'b0;
   int n_tr = 0;
   logic [3:0]        tr_cmd  [32];
   logic [BA_W-1:0]   tr_ba   [32];
   logic [ADDR_W-1:0] tr_addr [32];
   int                tr_cyc  [32];

   always @(posedge clk) begin
      cyc++;
      hi_run = (rst_n && pwr_stable) ? hi_run + 1 : 0;
   end

   always @(negedge clk) begin
      if (rec && cmd !== 4'b0111) begin
         if (n_tr < 32) begin
            tr_cmd[n_tr] = cmd; tr_ba[n_tr] = ba; tr_addr[n_tr] = addr; tr_cyc[n_tr] = cyc;
         end
         n_tr++;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected trace entry k: command, bank, address, gap from previous event.
   function automatic void exp_entry(int k, output logic [3:0] c, output int b,
                                     output int a, output int gap);
      b = 0; a = 0;
      if (k == 0)      begin c = 4'b0010; a = 1 << 10; gap = 1; end
      else if (k == 1) begin c = 4'b0000; b = 1; a = int'(EMODE_VAL); gap = T_RP; end
      else if (k == 2) begin c = 4'b0000; a = int'(MODE_VAL) | (1 << 8); gap = T_EMRS; end
      else if (k == 3) begin c = 4'b0010; a = 1 << 10; gap = T_MRS; end
      else if (k < 4 + N_REF) begin c = 4'b0001; gap = (k == 4) ? T_RP : T_RFC; end
      else             begin c = 4'b0000; a = int'(MODE_VAL) & ~(1 << 8); gap = T_RFC; end
   endfunction

   function automatic int max2(int x, int y);
      return (x > y) ? x : y;
   endfunction

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int cke_cyc, done_cyc, exp_done, prev, guard;
      logic [3:0] ec; int eb, ea, eg;
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; pwr_stable = 1'b0; freq_chg_req = 1'b0;
      for (int trial = 0; trial < 3; trial++) begin
         rst_n = 1'b0; pwr_stable = 1'b0; rec = 1'b0;
         repeat (3) @(negedge clk);
         chk("R1 reset cke", int'(cke), 0);
         chk("R1 reset cmd", int'(cmd), 7);
         chk("R9 reset done", int'(init_done), 0);
         rst_n = 1'b1; n_tr = 0; rec = 1'b1;
         // glitchy power-good shorter than the settling window
         repeat ($urandom_range(1, 3)) begin
            pwr_stable = 1'b1;
            repeat ($urandom_range(1, P - 2)) @(negedge clk);
            pwr_stable = 1'b0;
            repeat ($urandom_range(1, 5)) @(negedge clk);
         end
         chk("R1 cke low after glitches", int'(cke), 0);
         pwr_stable = 1'b1;
         guard = 0;
         while (!cke && guard < 4 * P) begin @(negedge clk); guard++; end
         chk("R1 cke rise edge count", hi_run, P);
         chk("R1 nop at cke rise", int'(cmd), 7);
         cke_cyc = cyc;
         // request during init must be ignored (R11)
         repeat ($urandom_range(1, 60)) @(negedge clk);
         freq_chg_req = 1'b1;
         @(negedge clk);
         freq_chg_req = 1'b0;
         guard = 0;
         while (!init_done && guard < 2000) begin
            @(negedge clk); guard++;
            if (!cke) chk("R2 cke held high", int'(cke), 1);
         end
         done_cyc = cyc;
         rec = 1'b0;
         chk("R11 trace length", n_tr, NE);
         prev = cke_cyc;
         for (int k = 0; k < NE && k < n_tr; k++) begin
            exp_entry(k, ec, eb, ea, eg);
            chk($sformatf("R3 cmd entry %0d", k), int'(tr_cmd[k]), int'(ec));
            chk($sformatf("R%0s entry %0d ba", (k == 1) ? "4" : "5", k), int'(tr_ba[k]), eb);
            if (k == 2)            chk("R5 dll reset addr", int'(tr_addr[k]), ea);
            else if (k == NE - 1)  chk("R8 final mode addr", int'(tr_addr[k]), ea);
            else                   chk($sformatf("R4 addr entry %0d", k), int'(tr_addr[k]), ea);
            if (k <= 1)            chk($sformatf("R4 gap entry %0d", k), tr_cyc[k] - prev, eg);
            else if (k == 2)       chk("R5 gap", tr_cyc[k] - prev, eg);
            else if (k == 3)       chk("R6 gap", tr_cyc[k] - prev, eg);
            else if (k < NE - 1)   chk($sformatf("R7 gap entry %0d", k), tr_cyc[k] - prev, eg);
            else                   chk("R8 gap", tr_cyc[k] - prev, eg);
            prev = tr_cyc[k];
         end
         if (n_tr >= NE) begin
            exp_done = max2(tr_cyc[NE - 1] + T_MRS, tr_cyc[2] + T_DLL);
            chk("R9 done cycle", done_cyc, exp_done);
         end
         // frequency-change relocks
         repeat (3) begin
            repeat ($urandom_range(2, 40)) begin
               @(negedge clk);
               chk("R9 idle bus while done", int'(cmd), 7);
               chk("R9 cke while done", int'(cke), 1);
            end
            freq_chg_req = 1'b1;
            @(negedge clk);
            freq_chg_req = 1'b0;
            chk("R10 relock cmd", int'(cmd), 0);
            chk("R10 relock ba", int'(ba), 0);
            chk("R10 relock addr", int'(addr), int'(MODE_VAL) | (1 << 8));
            chk("R10 done falls", int'(init_done), 0);
            prev = cyc;
            guard = 0;
            while (!init_done && guard < 1000) begin
               @(negedge clk); guard++;
               if (cmd !== 4'b0111) chk("R10 extra command", int'(cmd), 7);
            end
            chk("R10 relock time", cyc - prev, T_DLL);
         end
      end
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule